// File: doc/BRIEF.md
# Stuffed Video Lane Unpacker

This block sits behind three already deserialized colour lanes (blue, green, red) that share one link clock. Each lane delivers 10-bit characters with a per-lane valid strobe. When the pixel rate is low, the link clock runs at two or four times the pixel rate, and every pixel slot is padded with a fixed dummy code. The block removes that padding according to a programmed clock-to-pixel ratio. It also absorbs skew between the lanes in small per-lane elastic queues. For each pixel it hands one character per lane, together with a single valid strobe, to a downstream character decoder.

Alignment is taken from a marker character that the transmitter places on all three lanes during blanking. While the block is hunting, each lane throws away everything until its first marker. Reading starts once a marker sits at the head of all three queues, and the slot phase restarts at every marker that the lanes agree on. A malformed padding slot, a marker seen on only some of the lanes, or a queue overrun raises a sticky error. The block then flushes its queues and goes back to hunting.

Top module: `vid_lane_unpack`

## Requirements
- R1: `ratio_sel` selects the slot group: 2'b00 gives 1x (every slot is data), 2'b01 gives 2x (data, fill), and 2'b10 or 2'b11 give 4x (data, fill, fill, fill).
- R2: Slots after the first slot of a group must hold the fill code 10'b0001111010 on all lanes. These slots are dropped and produce no pixel.
- R3: The alignment marker is 10'b1101010100. While hunting, each lane discards every character before its first marker. A marker never produces a pixel.
- R4: Popping starts only when all three lane queues hold data, and the queues begin with the marker. Lane skew of up to 2 characters and common valid gaps leave the pixel stream unchanged.
- R5: Each data slot produces exactly one `pix_vld` pulse. In `pix_word`, bits [9:0] carry the blue lane, [19:10] the green lane and [29:20] the red lane. Pixels appear in arrival order.
- R6: When all lanes present a marker together, the slot phase resets, so the next character is a data slot even in the middle of a group.
- R7: A non-fill code on any lane in a fill slot sets `sync_error`, clears `locked`, and produces no pixel for that slot.
- R8: A marker at the queue head on some lanes but not on all of them sets `sync_error` and clears `locked`.
- R9: A write to a full lane queue that is not being read in the same cycle sets `sync_error` and clears `locked`.
- R10: `sync_error` stays set until reset. After an error, the queues are flushed and every lane hunts again. A later marker on all lanes relocks the block, and pixels resume.
- R11: Reset clears `pix_vld`, `sync_error` and `locked`.
- R12: At the 2x and 4x ratios, `pix_vld` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link character clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ratio_sel | input | 2 | Clock-to-pixel ratio select |
| blue_char | input | 10 | Blue lane character |
| blue_vld | input | 1 | Blue lane character valid |
| green_char | input | 10 | Green lane character |
| green_vld | input | 1 | Green lane character valid |
| red_char | input | 10 | Red lane character |
| red_vld | input | 1 | Red lane character valid |
| pix_vld | output | 1 | One pulse per unpacked pixel |
| pix_word | output | 30 | Pixel characters as {red, green, blue} |
| locked | output | 1 | Aligned and forwarding |
| sync_error | output | 1 | Sticky loss-of-sync flag |

## Verification
The hardest condition to reach from the ports is a queue overrun. With well-formed traffic, the read side drains every queue as soon as all lanes hold data, so no queue ever fills. The stimulus therefore starves the red lane completely while blue and green send a marker and a run of characters, which drives those two queues past their depth. Relocking after an error is reached in the same run: a full marker-led stream follows without a reset, and the bench expects a clean pixel sequence while the error flag remains set.

// File: rtl/vlu_pkg.sv
// Shared constants and types for the stuffed video lane unpacker.
// Assumes three lanes of 10-bit characters, lane 0 blue, 1 green, 2 red.
package vlu_pkg;
    localparam int CHAR_W    = 10;
    localparam int NUM_LANES = 3;
    localparam logic [CHAR_W-1:0] FILL_CODE = 10'b0001111010;
    localparam logic [CHAR_W-1:0] MARK_CODE = 10'b1101010100;

    typedef enum logic {ST_HUNT, ST_LOCK} seq_state_t;
endpackage

// File: rtl/vlu_lane_fifo.sv
// Per-lane elastic queue with hunt gating.
// Drops characters until the first marker after a flush, then stores the
// marker and everything after it. Flags a write that meets a full queue
// not being read. Assumes DEPTH is a power of two, at least 2.
module vlu_lane_fifo
    import vlu_pkg::*;
#(
    parameter int W = CHAR_W,
    parameter int DEPTH = 4,
    parameter logic [W-1:0] MARK = MARK_CODE
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         flush,
    input  logic [W-1:0] in_char,
    input  logic         in_vld,
    input  logic         rd_en,
    output logic [W-1:0] head,
    output logic         empty,
    output logic         overflow
);
    localparam int AW = $clog2(DEPTH);

    logic [AW:0]  wr_ptr, rd_ptr;
    logic [W-1:0] mem [DEPTH];
    logic         armed;
    logic         is_mark, want, full, push;

    // Classify the incoming character and decide whether it is stored.
    always_comb begin
        is_mark  = in_vld && (in_char == MARK);
        want     = in_vld && (armed || is_mark);
        full     = (wr_ptr[AW] != rd_ptr[AW]) && (wr_ptr[AW-1:0] == rd_ptr[AW-1:0]);
        empty    = (wr_ptr == rd_ptr);
        push     = want && (!full || rd_en);
        overflow = want && full && !rd_en;
        head     = mem[rd_ptr[AW-1:0]];
    end

    // Pointer update; flush empties the queue.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (push)  wr_ptr <= wr_ptr + 1'b1;
            if (rd_en) rd_ptr <= rd_ptr + 1'b1;
        end
    end

    // Hunt gate: opens on the first marker, closes on flush.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) armed <= 1'b0;
        else if (is_mark)    armed <= 1'b1;
    end

    // Storage write.
    always_ff @(posedge clk) begin
        if (push && !flush) mem[wr_ptr[AW-1:0]] <= in_char;
    end
endmodule

// File: rtl/vlu_slot_seq.sv
// Read-side slot sequencer.
// Pops one character from every lane whenever all queues hold data,
// tracks the slot phase, forwards data slots, checks fill slots and
// marker agreement, and raises a sticky error that flushes the lanes.
module vlu_slot_seq
    import vlu_pkg::*;
#(
    parameter int W = CHAR_W,
    parameter int LANES = NUM_LANES,
    parameter logic [W-1:0] FILL = FILL_CODE,
    parameter logic [W-1:0] MARK = MARK_CODE
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [1:0]         ratio_sel,
    input  logic [LANES*W-1:0] heads,
    input  logic [LANES-1:0]   lane_empty,
    input  logic               ovf_any,
    output logic               pop,
    output logic               flush,
    output logic               pix_vld,
    output logic [LANES*W-1:0] pix_word,
    output logic               locked,
    output logic               sync_error
);
    seq_state_t     state, nxt_state;
    logic [1:0]     phase, nxt_phase, last_phase;
    logic [LANES-1:0] mark_v, fill_v;
    logic           all_mark, any_mark, all_fill, err_evt, pix_evt;

    // Per-lane head classification.
    always_comb begin
        for (int l = 0; l < LANES; l++) begin
            mark_v[l] = (heads[l*W +: W] == MARK);
            fill_v[l] = (heads[l*W +: W] == FILL);
        end
        all_mark = &mark_v;
        any_mark = |mark_v;
        all_fill = &fill_v;
    end

    // Last phase index of a slot group for the selected ratio.
    always_comb begin
        case (ratio_sel)
            2'b00:   last_phase = 2'd0;
            2'b01:   last_phase = 2'd1;
            default: last_phase = 2'd3;
        endcase
    end

    // Slot decision: pop, forward, advance the phase or flag an error.
    always_comb begin
        pop       = ~|lane_empty;
        err_evt   = ovf_any;
        pix_evt   = 1'b0;
        nxt_state = state;
        nxt_phase = phase;
        if (pop) begin
            if (state == ST_HUNT) begin
                if (all_mark) begin
                    nxt_state = ST_LOCK;
                    nxt_phase = 2'd0;
                end else begin
                    err_evt = 1'b1;
                end
            end else if (all_mark) begin
                nxt_phase = 2'd0;
            end else if (any_mark) begin
                err_evt = 1'b1;
            end else if (phase == 2'd0) begin
                pix_evt   = 1'b1;
                nxt_phase = (last_phase == 2'd0) ? 2'd0 : 2'd1;
            end else if (all_fill) begin
                nxt_phase = (phase == last_phase) ? 2'd0 : phase + 2'd1;
            end else begin
                err_evt = 1'b1;
            end
        end
        if (err_evt) begin
            pix_evt   = 1'b0;
            nxt_state = ST_HUNT;
            nxt_phase = 2'd0;
        end
        flush = err_evt;
    end

    // State, phase and sticky error registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_HUNT;
            phase      <= 2'd0;
            sync_error <= 1'b0;
        end else begin
            state      <= nxt_state;
            phase      <= nxt_phase;
            sync_error <= sync_error | err_evt;
        end
    end

    // Registered pixel output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pix_vld  <= 1'b0;
            pix_word <= '0;
        end else begin
            pix_vld <= pix_evt;
            if (pix_evt) pix_word <= heads;
        end
    end

    assign locked = (state == ST_LOCK);
endmodule

// File: rtl/vid_lane_unpack.sv
// Top of the stuffed video lane unpacker.
// Three lane queues (blue, green, red) feed one slot sequencer; the
// pixel word is packed {red, green, blue} to match output channels 2..0.
// Assumes all lanes share clk and skew stays below DEPTH characters.
module vid_lane_unpack
    import vlu_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [1:0]                 ratio_sel,
    input  logic [CHAR_W-1:0]          blue_char,
    input  logic                       blue_vld,
    input  logic [CHAR_W-1:0]          green_char,
    input  logic                       green_vld,
    input  logic [CHAR_W-1:0]          red_char,
    input  logic                       red_vld,
    output logic                       pix_vld,
    output logic [NUM_LANES*CHAR_W-1:0] pix_word,
    output logic                       locked,
    output logic                       sync_error
);
    logic [NUM_LANES*CHAR_W-1:0] lane_char, heads;
    logic [NUM_LANES-1:0]        lane_vld, lane_empty, lane_ovf;
    logic                        pop, flush;

    assign lane_char = {red_char, green_char, blue_char};
    assign lane_vld  = {red_vld, green_vld, blue_vld};

    for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
        vlu_lane_fifo #(.W(CHAR_W), .DEPTH(DEPTH), .MARK(MARK_CODE)) i_fifo (
            .clk      (clk),
            .rst_n    (rst_n),
            .flush    (flush),
            .in_char  (lane_char[l*CHAR_W +: CHAR_W]),
            .in_vld   (lane_vld[l]),
            .rd_en    (pop),
            .head     (heads[l*CHAR_W +: CHAR_W]),
            .empty    (lane_empty[l]),
            .overflow (lane_ovf[l])
        );
    end

    vlu_slot_seq #(.W(CHAR_W), .LANES(NUM_LANES), .FILL(FILL_CODE), .MARK(MARK_CODE)) i_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .ratio_sel  (ratio_sel),
        .heads      (heads),
        .lane_empty (lane_empty),
        .ovf_any    (|lane_ovf),
        .pop        (pop),
        .flush      (flush),
        .pix_vld    (pix_vld),
        .pix_word   (pix_word),
        .locked     (locked),
        .sync_error (sync_error)
    );
endmodule

// File: rtl/vid_lane_unpack_chk.sv
// Property checker for vid_lane_unpack, attached by bind.
module vid_lane_unpack_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] ratio_sel,
    input logic       pix_vld,
    input logic       locked,
    input logic       sync_error,
    input logic       flush,
    input logic [2:0] lane_empty
);
    // R10: the error flag never clears without reset.
    p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        sync_error |=> sync_error);

    // R7: a new error always leaves the block unlocked.
    p_err_unlocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sync_error) |-> !locked);

    // R5: pixels only come out while aligned.
    p_pix_locked_r5: assert property (@(posedge clk) disable iff (!rst_n)
        pix_vld |-> locked);

    // R12: no back-to-back pixels at 2x and 4x.
    p_no_burst_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (ratio_sel != 2'b00 && pix_vld) |=> !pix_vld);

    // R10: a flush leaves every lane queue empty.
    p_flush_empties_r10: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (&lane_empty));
endmodule

bind vid_lane_unpack vid_lane_unpack_chk i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ratio_sel  (ratio_sel),
    .pix_vld    (pix_vld),
    .locked     (locked),
    .sync_error (sync_error),
    .flush      (flush),
    .lane_empty (lane_empty)
);

// File: tb/test_vid_lane_unpack.sv
`timescale 1ns/1ps
module test_vid_lane_unpack;
    localparam logic [9:0] FILL = 10'b0001111010;
    localparam logic [9:0] MARK = 10'b1101010100;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  ratio_sel = 2'b00;
    logic [9:0]  dch [3];
    logic        dvl [3];
    logic        pix_vld, locked, sync_error;
    logic [29:0] pix_word;

    always #4 clk = ~clk;

    vid_lane_unpack i_vid_lane_unpack (
        .clk(clk), .rst_n(rst_n), .ratio_sel(ratio_sel),
        .blue_char(dch[0]), .blue_vld(dvl[0]),
        .green_char(dch[1]), .green_vld(dvl[1]),
        .red_char(dch[2]), .red_vld(dvl[2]),
        .pix_vld(pix_vld), .pix_word(pix_word),
        .locked(locked), .sync_error(sync_error)
    );

    int nchk = 0, nfail = 0;
    bit done = 0;
    logic [9:0]  strm [3][80];
    int          slen [3];
    int          skew [3];
    bit          gaps;
    logic [29:0] expw [16];
    int          nexp, ngot, burst;
    bit          prev_vld;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [9:0] dval(input int p, input int l);
        int v;
        logic [9:0] r;
        v = (p * 97 + l * 311 + 19) % 1024;
        r = v[9:0];
        if (r == MARK) r = r ^ 10'd1;
        return r;
    endfunction

    task automatic put(input int l, input logic [9:0] v);
        strm[l][slen[l]] = v;
        slen[l]++;
    endtask

    task automatic put_all(input logic [9:0] v);
        for (int l = 0; l < 3; l++) put(l, v);
    endtask

    task automatic put_data(input int p);
        for (int l = 0; l < 3; l++) put(l, dval(p, l));
        expw[nexp] = {dval(p, 2), dval(p, 1), dval(p, 0)};
        nexp++;
    endtask

    task automatic group(input int p, input int n);
        put_data(p);
        for (int k = 1; k < n; k++) put_all(FILL);
    endtask

    task automatic clear_stream();
        for (int l = 0; l < 3; l++) begin slen[l] = 0; skew[l] = 0; end
        nexp = 0; ngot = 0; burst = 0; gaps = 0;
    endtask

    // Junk, marker, four groups, a partial group, marker, three groups.
    task automatic build_normal(input int n);
        clear_stream();
        for (int l = 0; l < 3; l++) begin put(l, 10'h0A5 + 10'(l)); put(l, 10'h2C3 + 10'(l)); end
        put_all(MARK);
        for (int p = 0; p < 4; p++) group(p, n);
        put_data(4);
        if (n > 1) put_all(FILL);
        put_all(MARK);
        for (int p = 5; p < 8; p++) group(p, n);
    endtask

    task automatic drive_idle();
        for (int l = 0; l < 3; l++) begin dvl[l] = 1'b0; dch[l] = 10'h0; end
    endtask

    task automatic monitor();
        if (rst_n && pix_vld) begin
            chk(ngot < nexp && pix_word == expw[ngot % 16], "R5 pixel word", {2'b0, pix_word},
                {2'b0, expw[ngot % 16]});
            if (prev_vld && ratio_sel != 2'b00) burst++;
            ngot++;
        end
        prev_vld = rst_n && pix_vld;
    endtask

    task automatic run();
        int idx [3];
        int c;
        bit pend;
        for (int l = 0; l < 3; l++) idx[l] = 0;
        c = 0;
        pend = 1;
        while (pend && c < 400) begin
            @(negedge clk);
            monitor();
            pend = 0;
            for (int l = 0; l < 3; l++) begin
                if (c >= skew[l] && idx[l] < slen[l] && !(gaps && (c % 5 == 4))) begin
                    dch[l] = strm[l][idx[l]];
                    dvl[l] = 1'b1;
                    idx[l]++;
                end else begin
                    dch[l] = 10'(c * 7);
                    dvl[l] = 1'b0;
                end
                if (idx[l] < slen[l]) pend = 1;
            end
            c++;
        end
        for (int k = 0; k < 12; k++) begin
            @(negedge clk);
            monitor();
            drive_idle();
        end
    endtask

    task automatic do_reset(input logic [1:0] r);
        @(negedge clk);
        rst_n = 1'b0;
        ratio_sel = r;
        drive_idle();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        prev_vld = 0;
        chk(!pix_vld && !sync_error && !locked, "R11 reset state",
            {29'b0, pix_vld, sync_error, locked}, 32'h0);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    initial begin
        drive_idle();
        // R1 R2 R3 R4 R6 sweep: every ratio code, lane skews 0..2, with and without gaps.
        for (int r = 0; r < 4; r++) begin
            for (int sk = 0; sk < 27; sk++) begin
                for (int g = 0; g < 2; g++) begin
                    do_reset(2'(r));
                    build_normal(r == 0 ? 1 : (r == 1 ? 2 : 4));
                    skew[0] = sk % 3; skew[1] = (sk / 3) % 3; skew[2] = sk / 9;
                    gaps = (g == 1);
                    run();
                    chk(ngot == nexp, "R1/R2/R3/R4/R6 pixel count", 32'(ngot), 32'(nexp));
                    chk(!sync_error && locked, "R4 clean lock", {30'b0, sync_error, locked}, 32'h1);
                    chk(burst == 0, "R12 no back-to-back pixels", 32'(burst), 32'h0);
                end
            end
        end

        // R7 and R10: bad fill slot, then relock on a later marker.
        do_reset(2'b10);
        clear_stream();
        put_all(MARK); group(0, 4); put_data(1);
        put(0, FILL); put(1, 10'h155); put(2, FILL);
        put_all(FILL); put_all(FILL);
        put_all(MARK); group(2, 4);
        run();
        chk(ngot == 3, "R7 pixels around bad fill", 32'(ngot), 32'h3);
        chk(sync_error, "R7 error on bad fill", {31'b0, sync_error}, 32'h1);
        chk(locked, "R10 relock after error", {31'b0, locked}, 32'h1);

        // R8: marker on the red lane only.
        do_reset(2'b10);
        clear_stream();
        put_all(MARK); group(0, 4);
        put(0, FILL); put(1, FILL); put(2, MARK);
        put_all(FILL); put_all(FILL);
        run();
        chk(ngot == 1, "R8 pixels before split marker", 32'(ngot), 32'h1);
        chk(sync_error && !locked, "R8 split marker error", {30'b0, sync_error, locked}, 32'h2);

        // R9: red lane starved while blue and green overrun their queues.
        do_reset(2'b01);
        clear_stream();
        put(0, MARK); put(1, MARK);
        for (int p = 0; p < 6; p++) begin put(0, dval(p, 0)); put(1, dval(p, 1)); end
        run();
        chk(ngot == 0, "R9 no pixels on overrun", 32'(ngot), 32'h0);
        chk(sync_error && !locked, "R9 overrun error", {30'b0, sync_error, locked}, 32'h2);

        // R10: full stream after the overrun, no reset in between.
        build_normal(2);
        run();
        chk(ngot == nexp, "R10 pixels after relock", 32'(ngot), 32'(nexp));
        chk(sync_error && locked, "R10 sticky error and relock", {30'b0, sync_error, locked}, 32'h3);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule